// File: doc/BRIEF.md
# Register-Controlled GPIO Port with Pin Interrupts

This block is a general-purpose I/O port of `NPINS` pins (32 by default) run by software through a small register bus. Each pin can be an input or a driven output. Writing to the output word changes all pins at once. Two extra write-only words let software raise or drop selected output bits without reading the register first. Input pins pass through a two-stage synchronizer. The synchronized word can be read back, and the same word feeds the interrupt logic.

Each pin has its own event detector. Three configuration bits pick how it triggers. A level-select bit chooses level or edge operation. A dual-edge bit makes any change count. A polarity bit picks high versus low level, or rising versus falling edge. Detected events latch into a status word, and software clears it by writing ones. The port drives a single registered interrupt line. That line is the OR, over all pins, of status that is both enabled and not masked. The pull enable and pull select words are storage only: their contents go out on output ports to the pad ring.

Register requests use a valid/ready handshake. A request with `req_write` low is a read, and its data comes back on a response channel with its own valid/ready pair. A response that the consumer holds off keeps its data stable. While it waits, the port accepts no new request, so `req_ready` drops and the requester is stalled.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset, every stored word is zero: output data, direction, pull enable, pull select, interrupt enable, mask, level select, dual edge, polarity and status. `irq` is 0, `pad_oe` is all zero and `rsp_valid` is 0.
- R2: `pad_oe[i]` equals direction bit i (1 = drive the pin), and `pad_out` equals the output data word. Word offsets are: 0x00 output data, 0x04 input data (read only), 0x08 direction.
- R3: A write to offset 0x0C sets every output bit whose written bit is 1. A write to offset 0x10 clears every output bit whose written bit is 1. Bits written as 0 keep their value, and both offsets read as zero.
- R4: A read of offset 0x04 returns `pad_in` as seen through two synchronizer flops. A pad change made between clock edges is readable once two edges have passed.
- R5: With level-select bit 0 and dual-edge bit 0, a pin latches status on a 0-to-1 change of its synchronized input when its polarity bit is 0, and on a 1-to-0 change when its polarity bit is 1. The change in the other direction latches nothing. Level select is at 0x28, dual edge at 0x2C and polarity at 0x30.
- R6: With level-select bit 0 and dual-edge bit 1, a pin latches status on a change in either direction, whatever its polarity bit.
- R7: With level-select bit 1, a pin latches status in every cycle its synchronized input is high (polarity 0) or low (polarity 1). A clear written while that level persists leaves the status bit set.
- R8: The status word is read at offset 0x20. Writing to 0x20 clears exactly the status bits written as 1. If an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R9: A pin latches status only while its enable bit (offset 0x1C) is 1. With an enable bit of 0, the pin contributes nothing to `irq`.
- R10: A mask bit of 1 (offset 0x24) keeps its pin's status from reaching `irq`, but the status is still latched and still readable.
- R11: `irq` is a register. It goes to 1 one cycle after some pin has status, enable 1 and mask 0 all at the same time, and goes to 0 one cycle after no pin does.
- R12: A read returns its data with `rsp_valid` one cycle after it is accepted. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_rdata` stays constant and `req_ready` is 0.
- R13: Pull enable (0x14) and pull select (0x18) read back what was written and drive `pull_en` and `pull_sel`. A request whose two low address bits are not zero changes no register and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | NPINS | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | NPINS | Read data |
| pad_in | input | NPINS | Asynchronous pin inputs |
| pad_out | output | NPINS | Pin output values |
| pad_oe | output | NPINS | Pin output enables |
| pull_en | output | NPINS | Stored pull enable per pin |
| pull_sel | output | NPINS | Stored pull direction per pin |
| irq | output | 1 | Combined registered interrupt |

## Verification
The assertions check the following on every cycle: a stalled read response stays stable, set and clear writes land on the output word, latched status persists until it is cleared, a detected event always latches even against a clear, a disabled pin stays quiet, and a zero enable word silences `irq`. Only the bench scenarios can show that each trigger mode picks the right edges or levels from real pad sequences, and that the synchronizer delay is correct. The same holds for partial clears and masking, and for the register offsets and read-back values, because these depend on the meaning of the configuration rather than on any single cycle's relation.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // word indices (byte offset = index * 4)
  localparam int REG_OUT     = 0;
  localparam int REG_IN      = 1;
  localparam int REG_DIR     = 2;
  localparam int REG_SET     = 3;
  localparam int REG_CLR     = 4;
  localparam int REG_PULLEN  = 5;
  localparam int REG_PULLSEL = 6;
  localparam int REG_IEN     = 7;
  localparam int REG_ISTAT   = 8;
  localparam int REG_IMASK   = 9;
  localparam int REG_TLVL    = 10;
  localparam int REG_DUAL    = 11;
  localparam int REG_POL     = 12;

  typedef struct packed {
    logic lvl;
    logic dual;
    logic pol;
  } trig_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event
  import gpio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      smp,
  input  trig_cfg_t cfg,
  input  logic      en,
  input  logic      clr,
  output logic      status
);
  logic prev_q;
  logic hit;
  logic evt;

  always_comb begin
    if (cfg.lvl)       hit = cfg.pol ? ~smp : smp;
    else if (cfg.dual) hit = smp ^ prev_q;
    else if (cfg.pol)  hit = prev_q & ~smp;
    else               hit = smp & ~prev_q;
  end

  assign evt = en & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      status <= 1'b0;
    end else begin
      prev_q <= smp;
      status <= (status & ~clr) | evt;
    end
  end

  // R8: status holds until a clear
  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status);
  // R8: a detected event wins over a clear in the same cycle
  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> status);
  // R9: disabled pin never latches
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !status) |=> !status);
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPINS-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NPINS-1:0]  rsp_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pull_en,
  output logic [NPINS-1:0]  pull_sel,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word;
  logic             aligned;
  logic             acc;
  logic             wr;
  int               widx;

  logic [NPINS-1:0] out_q, dir_q, pen_q, psel_q;
  logic [NPINS-1:0] ien_q, imask_q, tlvl_q, dual_q, pol_q;
  logic [NPINS-1:0] smp, status, clr_vec, rd_val;
  logic             irq_q;

  assign word      = req_addr[ADDR_W-1:2];
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign widx      = int'(word);
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write && aligned;

  // configuration and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      pen_q   <= '0;
      psel_q  <= '0;
      ien_q   <= '0;
      imask_q <= '0;
      tlvl_q  <= '0;
      dual_q  <= '0;
      pol_q   <= '0;
    end else if (wr) begin
      case (widx)
        REG_OUT:     out_q   <= req_wdata;
        REG_SET:     out_q   <= out_q | req_wdata;
        REG_CLR:     out_q   <= out_q & ~req_wdata;
        REG_DIR:     dir_q   <= req_wdata;
        REG_PULLEN:  pen_q   <= req_wdata;
        REG_PULLSEL: psel_q  <= req_wdata;
        REG_IEN:     ien_q   <= req_wdata;
        REG_IMASK:   imask_q <= req_wdata;
        REG_TLVL:    tlvl_q  <= req_wdata;
        REG_DUAL:    dual_q  <= req_wdata;
        REG_POL:     pol_q   <= req_wdata;
        default:     ;
      endcase
    end
  end

  assign clr_vec = (wr && widx == REG_ISTAT) ? req_wdata : '0;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (smp)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    trig_cfg_t cfg;
    assign cfg.lvl  = tlvl_q[i];
    assign cfg.dual = dual_q[i];
    assign cfg.pol  = pol_q[i];
    gpio_pin_event u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .smp   (smp[i]),
      .cfg   (cfg),
      .en    (ien_q[i]),
      .clr   (clr_vec[i]),
      .status(status[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status & ien_q & ~imask_q);
  end
  assign irq = irq_q;

  // read path
  always_comb begin
    rd_val = '0;
    if (aligned) begin
      case (widx)
        REG_OUT:     rd_val = out_q;
        REG_IN:      rd_val = smp;
        REG_DIR:     rd_val = dir_q;
        REG_PULLEN:  rd_val = pen_q;
        REG_PULLSEL: rd_val = psel_q;
        REG_IEN:     rd_val = ien_q;
        REG_ISTAT:   rd_val = status;
        REG_IMASK:   rd_val = imask_q;
        REG_TLVL:    rd_val = tlvl_q;
        REG_DUAL:    rd_val = dual_q;
        REG_POL:     rd_val = pol_q;
        default:     rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign pad_out  = out_q;
  assign pad_oe   = dir_q;
  assign pull_en  = pen_q;
  assign pull_sel = psel_q;

  // R12: stalled response holds its data and blocks requests
  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_req_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R3: set and clear writes reach the pins
  assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == REG_SET) |=> ((pad_out & $past(req_wdata)) == $past(req_wdata)));
  assert_clr_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == REG_CLR) |=> ((pad_out & $past(req_wdata)) == '0));
  // R9: no enabled pin means no interrupt next cycle
  assert_no_enable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |=> !irq);
endmodule

// File: tb/gpio_port_irq_bench.sv
module gpio_port_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [N-1:0]  req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [N-1:0]  rsp_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe, pull_en, pull_sel;
  logic          irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_irq #(.NPINS(N), .ADDR_W(AW)) u_gpio_port_irq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_en(pull_en), .pull_sel(pull_sel), .irq(irq)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data on each response handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R12 unexpected response act=%h exp=none", rsp_rdata);
      end else begin
        automatic logic [N-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rsp_rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [N-1:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, '0);
    check("R1 pad_oe", pad_oe, '0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, '0);
    bus_read(8'h00, '0, "R1 out");
    bus_read(8'h08, '0, "R1 dir");
    bus_read(8'h1C, '0, "R1 ien");
    bus_read(8'h20, '0, "R1 status");
    bus_read(8'h30, '0, "R1 pol");

    // R2 direction and output data
    bus_write(8'h08, 32'h0000_00FF);
    bus_write(8'h00, 32'h0000_00A5);
    bus_read(8'h08, 32'h0000_00FF, "R2 dir");
    check("R2 pad_oe", pad_oe, 32'h0000_00FF);
    check("R2 pad_out", pad_out, 32'h0000_00A5);

    // R3 set/clear
    bus_write(8'h0C, 32'h0000_0F00);
    bus_read(8'h00, 32'h0000_0FA5, "R3 set");
    bus_write(8'h10, 32'h0000_0005);
    bus_read(8'h00, 32'h0000_0FA0, "R3 clr");
    check("R3 pad_out", pad_out, 32'h0000_0FA0);
    bus_read(8'h0C, '0, "R3 set reads zero");

    // R13 pull storage and misaligned access
    bus_write(8'h14, 32'h0000_003C);
    bus_write(8'h18, 32'h0000_0014);
    bus_read(8'h14, 32'h0000_003C, "R13 pullen");
    check("R13 pull_sel", pull_sel, 32'h0000_0014);
    bus_write(8'h09, '0);
    bus_read(8'h08, 32'h0000_00FF, "R13 misaligned write ignored");
    bus_read(8'h41, '0, "R13 misaligned read");

    // R4 input sync
    pad_in = 32'h1234_5678;
    settle();
    bus_read(8'h04, 32'h1234_5678, "R4 in");
    pad_in = '0;
    settle();
    bus_read(8'h20, '0, "R9 no status while disabled");

    // R5 edges on pin 0
    bus_write(8'h1C, 32'h1);
    pad_in = 32'h1; settle();
    bus_read(8'h20, 32'h1, "R5 rising");
    check("R11 irq set", {31'b0, irq}, 32'h1);
    bus_write(8'h20, 32'h1); settle();
    bus_read(8'h20, '0, "R8 cleared");
    check("R11 irq drop", {31'b0, irq}, '0);
    pad_in = 32'h0; settle();
    bus_read(8'h20, '0, "R5 falling ignored");
    bus_write(8'h30, 32'h1);
    pad_in = 32'h1; settle();
    bus_read(8'h20, '0, "R5 rising ignored pol1");
    pad_in = 32'h0; settle();
    bus_read(8'h20, 32'h1, "R5 falling pol1");
    bus_write(8'h20, 32'hFFFF_FFFF);

    // R6 both edges on pin 1
    bus_write(8'h30, '0);
    bus_write(8'h1C, 32'h2);
    bus_write(8'h2C, 32'h2);
    pad_in = 32'h2; settle();
    bus_read(8'h20, 32'h2, "R6 rise");
    bus_write(8'h20, 32'h2);
    pad_in = 32'h0; settle();
    bus_read(8'h20, 32'h2, "R6 fall");
    bus_write(8'h20, 32'h2);
    bus_read(8'h20, '0, "R6 cleared");

    // R7 level on pin 2
    bus_write(8'h2C, '0);
    bus_write(8'h1C, 32'h4);
    bus_write(8'h28, 32'h4);
    pad_in = 32'h4; settle();
    bus_read(8'h20, 32'h4, "R7 high");
    bus_write(8'h20, 32'h4); settle();
    bus_read(8'h20, 32'h4, "R7 persists");
    pad_in = 32'h0; settle();
    bus_write(8'h20, 32'h4);
    bus_read(8'h20, '0, "R7 gone");
    bus_write(8'h30, 32'h4); settle();
    bus_read(8'h20, 32'h4, "R7 low");
    bus_write(8'h30, '0);
    bus_write(8'h20, 32'h4);
    bus_read(8'h20, '0, "R7 low cleared");

    // R9 disabled pin 3
    bus_write(8'h1C, '0);
    bus_write(8'h28, '0);
    pad_in = 32'h8; settle();
    bus_read(8'h20, '0, "R9 disabled");
    check("R9 irq", {31'b0, irq}, '0);

    // R10 mask, R11 unmask
    bus_write(8'h1C, 32'h8);
    bus_write(8'h24, 32'h8);
    bus_write(8'h30, 32'h8);
    pad_in = 32'h0; settle();
    bus_read(8'h20, 32'h8, "R10 status latched");
    check("R10 irq masked", {31'b0, irq}, '0);
    bus_write(8'h24, '0); settle();
    check("R11 irq unmasked", {31'b0, irq}, 32'h1);
    bus_write(8'h1C, '0); settle();
    check("R9 irq disabled", {31'b0, irq}, '0);

    // R8 partial clear
    bus_write(8'h1C, 32'h9);
    bus_write(8'h30, 32'h9);
    pad_in = 32'h9; settle();
    pad_in = 32'h0; settle();
    bus_read(8'h20, 32'h9, "R8 two pending");
    bus_write(8'h20, 32'h1);
    bus_read(8'h20, 32'h8, "R8 partial clear");
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h20, '0, "R8 clear all");

    // R12 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    bus_read(8'h00, 32'h0000_0FA0, "R12 stalled read");
    repeat (3) @(negedge clk);
    check("R12 rsp held", {31'b0, rsp_valid}, 32'h1);
    check("R12 req blocked", {31'b0, req_ready}, '0);
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (3) @(negedge clk);

    check("R12 all responses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule